// File: doc/BRIEF.md
# Set-Associative Cache Tag Model

This block models the bookkeeping side of a set-associative cache. It keeps, for every line, only a valid bit, a tag and a recency stamp. Each data access in an incoming trace stream is classified as a hit, a miss, or a miss that displaces a resident line. No data payload is stored. The geometry is set by three parameters: the number of set-index bits, the number of ways, and the number of block-offset bits. The block keeps three running counters (hits, misses, evictions), so a whole trace can be scored by streaming it through and reading the counters at the end.

Trace operations enter on a valid/ready port, one per transfer, each an opcode plus an address. The input is accepted on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the producer must hold its operation; nothing is taken. `in_ready` drops for exactly one cycle after a modify is accepted, while that modify's second access runs. At all other times it is high. Each data access reports its outcome on a one-cycle `res_valid` strobe with a 3-bit flag vector. The result path cannot be stalled: the consumer must take every strobe.

Replacement is least-recently-used. A single global stamp advances on every data access, and each line records the stamp of its last use. Invalid ways are filled lowest index first. On a miss to a full set, the valid way with the smallest stamp is replaced.

Top module: `tagdir_model`

## Requirements
- R1: For each access the set index is (address >> OFFSET_BITS) masked to SET_BITS bits, and the tag is address >> (SET_BITS + OFFSET_BITS). With 4 set bits, 1 way and 4 offset bits, addresses 0x10 and 0x110 share set 1 and therefore displace each other.
- R2: With SET_BITS = 0 every address maps to the single set, so any WAYS+1 distinct tags conflict with each other.
- R3: `res_flags` uses bit 0 = hit, bit 1 = miss, bit 2 = eviction. Its only values are 1, 2 and 6. It is valid, with `res_valid` high for one cycle, on the clock edge that performs the access, which for a single access is the edge that accepts it.
- R4: A hit refreshes the matching line's recency with the current stamp, increments `hit_count`, and reports 1.
- R5: A miss to a set that has an invalid way fills one invalid way, increments `miss_count`, reports 2, and leaves `evict_count` unchanged.
- R6: A miss to a full set replaces the least recently used valid way, increments both `miss_count` and `evict_count`, and reports 6. Evictions are counted in no other case.
- R7: Opcode 1 (load) and opcode 2 (store) each make one access. Opcode 3 (modify) makes two accesses to the same address on consecutive edges, and the second always reports 1. `in_ready` is low for the one cycle between these two accesses.
- R8: Opcode 0 (instruction fetch) is accepted but ignored. It produces no result strobe, changes no counter, and does not advance the stamp.
- R9: A synchronous active-high `rst` clears all valid bits, the stamp, the pending modify and all three counters. After reset, every address misses.
- R10: The counters are CNT_W bits wide and saturate at their maximum value instead of wrapping.
- R11: With 4 set bits, 1 way and 4 offset bits, the trace L 0x10, M 0x20, L 0x22, S 0x18, L 0x110, L 0x210, M 0x12 ends with 4 hits, 5 misses and 3 evictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Trace operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 2 | Opcode: 0 fetch, 1 load, 2 store, 3 modify |
| in_addr | input | ADDR_W | Byte address of the operation |
| res_valid | output | 1 | One-cycle strobe per completed data access |
| res_flags | output | 3 | Outcome: 1 hit, 2 miss, 6 miss with eviction |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |
| evict_count | output | CNT_W | Saturating eviction total |

## Verification
The hardest condition to reach from the ports is an eviction whose victim is decided by recency rather than by fill order. This needs a full multi-way set where a hit has reordered the lines before the conflicting miss arrives. The stimulus first fills one set of a four-way instance with four tags, then interleaves hits to chosen tags with new tags, so that each eviction's victim can only be predicted if the hit refreshes were honoured. Counter saturation is reached through a zero-set-bit, two-way instance with narrow counters, driven by a cyclic three-tag pattern that misses on every access. Ignored fetches are exposed by following each one with a load to the same address, which would hit if the fetch had filled a line.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_MODIFY = 2'd3
  } op_e;

  localparam logic [2:0] FLAG_HIT   = 3'b001;
  localparam logic [2:0] FLAG_MISS  = 3'b010;
  localparam logic [2:0] FLAG_EVICT = 3'b100;
endpackage

// File: rtl/tagdir_addr_split.sv
module tagdir_addr_split #(
  parameter int ADDR_W      = 32,
  parameter int SET_BITS    = 4,
  parameter int OFFSET_BITS = 4,
  localparam int SET_W      = (SET_BITS > 0) ? SET_BITS : 1,
  localparam int TAG_W      = ADDR_W - SET_BITS - OFFSET_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag
);
  localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'((64'd1 << SET_BITS) - 64'd1);

  logic [ADDR_W-1:0] shifted_set;
  logic [ADDR_W-1:0] shifted_tag;

  always_comb begin
    shifted_set = (addr >> OFFSET_BITS) & SET_MASK;
    shifted_tag = addr >> (SET_BITS + OFFSET_BITS);
    set_idx     = shifted_set[SET_W-1:0];
    tag         = shifted_tag[TAG_W-1:0];
  end
endmodule

// File: rtl/tagdir_way_select.sv
module tagdir_way_select #(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 24,
  parameter int STAMP_W = 32,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
  input  logic [WAYS-1:0][STAMP_W-1:0] way_stamp,
  input  logic [TAG_W-1:0]             probe_tag,
  output logic                         hit,
  output logic [WAY_W-1:0]             hit_way,
  output logic                         free_any,
  output logic [WAY_W-1:0]             free_way,
  output logic [WAY_W-1:0]             victim_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_valid[g] && (way_tag[g] == probe_tag);
  end

  // Lowest matching way; at most one can match in a consistent directory.
  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  // Lowest invalid way receives a fill.
  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) free_way = WAY_W'(i);
    end
  end

  // Oldest valid way; a strict compare keeps the lower index on a tie.
  always_comb begin
    logic [STAMP_W-1:0] oldest;
    logic               seen;
    victim_way = '0;
    oldest     = '0;
    seen       = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_valid[i] && (!seen || way_stamp[i] < oldest)) begin
        oldest     = way_stamp[i];
        victim_way = WAY_W'(i);
        seen       = 1'b1;
      end
    end
  end

  assign hit      = |match;
  assign free_any = ~&way_valid;
endmodule

// File: rtl/tagdir_sat_counter.sv
module tagdir_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                     count <= '0;
    else if (inc && count != '1) count <= count + 1'b1;
  end
endmodule

// File: rtl/tagdir_model.sv
module tagdir_model #(
  parameter int ADDR_W      = 32,
  parameter int SET_BITS    = 4,
  parameter int WAYS        = 4,
  parameter int OFFSET_BITS = 4,
  parameter int CNT_W       = 32,
  parameter int STAMP_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              res_valid,
  output logic [2:0]        res_flags,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);
  import tagdir_pkg::*;

  localparam int NSETS = 1 << SET_BITS;
  localparam int SET_W = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_W = ADDR_W - SET_BITS - OFFSET_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]              valid_q [NSETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q   [NSETS];
  logic [WAYS-1:0][STAMP_W-1:0] stamp_q [NSETS];

  logic [STAMP_W-1:0] now_q, now_next;
  logic               pend_q;
  logic [ADDR_W-1:0]  pend_addr_q;

  logic              take;
  logic              take_modify;
  logic              acc_fire;
  logic [ADDR_W-1:0] acc_addr;
  logic [SET_W-1:0]  acc_set;
  logic [TAG_W-1:0]  acc_tag;

  logic             hit, free_any;
  logic [WAY_W-1:0] hit_way, free_way, victim_way;

  assign in_ready    = !pend_q;
  assign take        = in_valid && in_ready;
  assign take_modify = take && (op_e'(in_op) == OP_MODIFY);
  // The held second half of a modify wins the access slot.
  assign acc_fire    = pend_q || (take && (op_e'(in_op) != OP_FETCH));
  assign acc_addr    = pend_q ? pend_addr_q : in_addr;
  assign now_next    = now_q + 1'b1;

  tagdir_addr_split #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFFSET_BITS(OFFSET_BITS)
  ) u_split (
    .addr(acc_addr), .set_idx(acc_set), .tag(acc_tag)
  );

  tagdir_way_select #(
    .WAYS(WAYS), .TAG_W(TAG_W), .STAMP_W(STAMP_W)
  ) u_select (
    .way_valid (valid_q[acc_set]),
    .way_tag   (tag_q[acc_set]),
    .way_stamp (stamp_q[acc_set]),
    .probe_tag (acc_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .free_any  (free_any),
    .free_way  (free_way),
    .victim_way(victim_way)
  );

  // Control state, valid bits and the result strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) valid_q[s] <= '0;
      now_q       <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      res_valid   <= 1'b0;
      res_flags   <= '0;
    end else begin
      res_valid <= acc_fire;
      pend_q    <= take_modify;
      if (take_modify) pend_addr_q <= in_addr;
      if (acc_fire) begin
        now_q <= now_next;
        if (hit) begin
          res_flags <= FLAG_HIT;
        end else if (free_any) begin
          valid_q[acc_set][free_way] <= 1'b1;
          res_flags <= FLAG_MISS;
        end else begin
          res_flags <= FLAG_MISS | FLAG_EVICT;
        end
      end
    end
  end

  // Tag and recency storage; contents behind a clear valid bit are don't-care.
  always_ff @(posedge clk) begin
    if (!rst && acc_fire) begin
      if (hit) begin
        stamp_q[acc_set][hit_way] <= now_next;
      end else if (free_any) begin
        tag_q[acc_set][free_way]   <= acc_tag;
        stamp_q[acc_set][free_way] <= now_next;
      end else begin
        tag_q[acc_set][victim_way]   <= acc_tag;
        stamp_q[acc_set][victim_way] <= now_next;
      end
    end
  end

  logic [2:0]       cnt_inc;
  logic [CNT_W-1:0] cnt_val [3];

  assign cnt_inc[0] = acc_fire && hit;
  assign cnt_inc[1] = acc_fire && !hit;
  assign cnt_inc[2] = acc_fire && !hit && !free_any;

  for (genvar c = 0; c < 3; c++) begin : g_cnt
    tagdir_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cnt_inc[c]), .count(cnt_val[c])
    );
  end

  assign hit_count   = cnt_val[0];
  assign miss_count  = cnt_val[1];
  assign evict_count = cnt_val[2];
endmodule

// File: rtl/tagdir_model_checker.sv
module tagdir_model_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [ADDR_W-1:0] in_addr,
  input logic              res_valid,
  input logic [2:0]        res_flags,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic [CNT_W-1:0]  evict_count
);
  logic acc_mod, acc_fetch;
  assign acc_mod   = in_valid && in_ready && (in_op == 2'd3);
  assign acc_fetch = in_valid && in_ready && (in_op == 2'd0);

  a_r3_legal_flags: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_flags == 3'd1 || res_flags == 3'd2 || res_flags == 3'd6));

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(hit_count) != '1 && $past(miss_count) != '1) |->
      ({1'b0, hit_count} + {1'b0, miss_count} ==
       {1'b0, $past(hit_count)} + {1'b0, $past(miss_count)} + 1'b1));

  a_r6_evict_bound: assert property (@(posedge clk) disable iff (rst)
    evict_count <= miss_count);

  a_r7_modify_stall: assert property (@(posedge clk) disable iff (rst)
    acc_mod |=> !in_ready);

  a_r7_modify_second_hit: assert property (@(posedge clk) disable iff (rst)
    acc_mod |=> res_valid ##1 (res_valid && res_flags == 3'd1));

  a_r8_fetch_quiet: assert property (@(posedge clk) disable iff (rst)
    acc_fetch |=> (!res_valid && $stable(hit_count) && $stable(miss_count) && $stable(evict_count)));

  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && in_ready && hit_count == '0 && miss_count == '0 && evict_count == '0));
endmodule

bind tagdir_model tagdir_model_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_addr(in_addr), .res_valid(res_valid), .res_flags(res_flags),
  .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count)
);

// File: tb/tagdir_model_test.sv
module tagdir_model_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'd0;
  logic [31:0] in_addr = '0;

  always #2 clk = ~clk;

  // a: 4 set bits, 1 way; b: 4 set bits, 4 ways; c: 0 set bits, 2 ways, 3-bit counters
  logic a_rdy, a_rv, b_rdy, b_rv, c_rdy, c_rv;
  logic [2:0] a_fl, b_fl, c_fl;
  logic [31:0] a_h, a_m, a_e, b_h, b_m, b_e;
  logic [2:0] c_h, c_m, c_e;

  tagdir_model #(.SET_BITS(4), .WAYS(1), .OFFSET_BITS(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(a_rdy), .in_op(in_op),
    .in_addr(in_addr), .res_valid(a_rv), .res_flags(a_fl),
    .hit_count(a_h), .miss_count(a_m), .evict_count(a_e));

  tagdir_model #(.SET_BITS(4), .WAYS(4), .OFFSET_BITS(4)) uut_assoc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_rdy), .in_op(in_op),
    .in_addr(in_addr), .res_valid(b_rv), .res_flags(b_fl),
    .hit_count(b_h), .miss_count(b_m), .evict_count(b_e));

  tagdir_model #(.SET_BITS(0), .WAYS(2), .OFFSET_BITS(4), .CNT_W(3)) uut_flat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_rdy), .in_op(in_op),
    .in_addr(in_addr), .res_valid(c_rv), .res_flags(c_fl),
    .hit_count(c_h), .miss_count(c_m), .evict_count(c_e));

  int checks = 0;
  int errors = 0;
  int xah, xam, xae, xbh, xbm, xbe, xch, xcm, xce;

  // {op, addr, flags for uut, flags for uut_assoc}
  localparam int NV = 17;
  localparam logic [39:0] VEC [NV] = '{
    {2'd1, 32'h010, 3'd2, 3'd2}, {2'd3, 32'h020, 3'd2, 3'd2},
    {2'd1, 32'h022, 3'd1, 3'd1}, {2'd2, 32'h018, 3'd1, 3'd1},
    {2'd1, 32'h110, 3'd6, 3'd2}, {2'd1, 32'h210, 3'd6, 3'd2},
    {2'd3, 32'h012, 3'd6, 3'd1},
    {2'd1, 32'h130, 3'd2, 3'd2}, {2'd1, 32'h230, 3'd6, 3'd2},
    {2'd1, 32'h330, 3'd6, 3'd2}, {2'd1, 32'h430, 3'd6, 3'd2},
    {2'd1, 32'h130, 3'd6, 3'd1}, {2'd1, 32'h530, 3'd6, 3'd6},
    {2'd1, 32'h130, 3'd6, 3'd1}, {2'd1, 32'h230, 3'd6, 3'd6},
    {2'd1, 32'h430, 3'd6, 3'd1}, {2'd1, 32'h330, 3'd6, 3'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tally(input logic [2:0] fa, input logic [2:0] fb, input logic [2:0] fc);
    if (fa == 3'd1) xah++; if (fa[1]) xam++; if (fa[2]) xae++;
    if (fb == 3'd1) xbh++; if (fb[1]) xbm++; if (fb[2]) xbe++;
    if (fc == 3'd1 && xch < 7) xch++;
    if (fc[1] && xcm < 7) xcm++;
    if (fc[2] && xce < 7) xce++;
  endtask

  task automatic check_counts(input bit with_c);
    chk("R4 uut hits", a_h, xah); chk("R5 uut misses", a_m, xam); chk("R6 uut evictions", a_e, xae);
    chk("R4 assoc hits", b_h, xbh); chk("R5 assoc misses", b_m, xbm); chk("R6 assoc evictions", b_e, xbe);
    if (with_c) begin
      chk("R10 flat hits", {29'd0, c_h}, xch);
      chk("R10 flat misses", {29'd0, c_m}, xcm);
      chk("R10 flat evictions", {29'd0, c_e}, xce);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                       input logic [2:0] fa, input logic [2:0] fb, input logic [2:0] fc,
                       input bit with_c, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = addr;
    @(negedge clk);
    in_valid = 1'b0;
    if (op == 2'd0) begin
      chk({req, " fetch strobe uut"}, {31'd0, a_rv}, 32'd0);
      chk({req, " fetch strobe assoc"}, {31'd0, b_rv}, 32'd0);
    end else begin
      chk({req, " R3 strobe"}, {31'd0, a_rv & b_rv}, 32'd1);
      chk({req, " uut flags"}, {29'd0, a_fl}, {29'd0, fa});
      chk({req, " assoc flags"}, {29'd0, b_fl}, {29'd0, fb});
      if (with_c) chk({req, " flat flags"}, {29'd0, c_fl}, {29'd0, fc});
      tally(fa, fb, with_c ? fc : 3'd0);
      if (op == 2'd3) begin
        chk("R7 ready low during modify", {31'd0, a_rdy}, 32'd0);
        @(negedge clk);
        chk("R7 second access strobe", {31'd0, a_rv & b_rv}, 32'd1);
        chk("R7 second access hits uut", {29'd0, a_fl}, 32'd1);
        chk("R7 second access hits assoc", {29'd0, b_fl}, 32'd1);
        if (with_c) chk("R7 second access hits flat", {29'd0, c_fl}, 32'd1);
        tally(3'd1, 3'd1, with_c ? 3'd1 : 3'd0);
      end
    end
    chk({req, " ready"}, {31'd0, a_rdy}, 32'd1);
    check_counts(with_c);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    xah = 0; xam = 0; xae = 0; xbh = 0; xbm = 0; xbe = 0; xch = 0; xcm = 0; xce = 0;
    chk("R9 reset ready", {31'd0, a_rdy & b_rdy & c_rdy}, 32'd1);
    chk("R9 reset strobe", {31'd0, a_rv | b_rv | c_rv}, 32'd0);
    check_counts(1'b1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    apply_reset();
    // R1 R11 R6 R4: trace replay and LRU ordering table
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][39:38], VEC[i][37:6], VEC[i][5:3], VEC[i][2:0], 3'd0, 1'b0, "R1 R6 table");
      if (i == 6) begin
        chk("R11 trace hits", a_h, 32'd4);
        chk("R11 trace misses", a_m, 32'd5);
        chk("R11 trace evictions", a_e, 32'd3);
      end
    end

    apply_reset();
    // R2 single set, R10 saturation on the 3-bit counters
    do_op(2'd1, 32'h000, 3'd2, 3'd2, 3'd2, 1'b1, "R2 R5 fill");
    do_op(2'd1, 32'h100, 3'd6, 3'd2, 3'd2, 1'b1, "R2 R5 fill");
    do_op(2'd1, 32'h200, 3'd6, 3'd2, 3'd6, 1'b1, "R2 R6 evict");
    for (int k = 0; k < 6; k++)
      do_op(2'd1, 32'h100 * (k % 3), 3'd6, 3'd1, 3'd6, 1'b1, "R2 R10 cycle");
    chk("R10 miss saturated", {29'd0, c_m}, 32'd7);
    chk("R10 evict saturated", {29'd0, c_e}, 32'd7);
    do_op(2'd1, 32'h200, 3'd1, 3'd1, 3'd1, 1'b1, "R4 hit");

    // R8: fetch ignored, then the same address must still miss
    do_op(2'd0, 32'h300, 3'd0, 3'd0, 3'd0, 1'b1, "R8");
    do_op(2'd1, 32'h300, 3'd6, 3'd2, 3'd6, 1'b1, "R8 after fetch");
    do_op(2'd2, 32'h300, 3'd1, 3'd1, 3'd1, 1'b1, "R7 store");
    do_op(2'd3, 32'h100, 3'd6, 3'd1, 3'd6, 1'b1, "R7 modify");

    // R9: valid bits cleared by reset
    apply_reset();
    do_op(2'd1, 32'h300, 3'd2, 3'd2, 3'd2, 1'b1, "R9 miss after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule